// File: doc/BRIEF.md
# Circular Host Buffer Write-Pointer Controller

This block drains fixed-size blocks from an on-chip FIFO into one contiguous ring of host memory, issuing write requests back to back without descriptors. Every request carries a destination address and a byte length and is followed by a stream of data beats taken straight from the FIFO. The hardware owns the write pointer and advances it one block at a time. Host software owns the read pointer and writes it through a register to report how far it has consumed the ring.

The ring is described by a base address and a size counted in blocks. Each pointer carries a wrap bit, so a ring holding no unread blocks can be told apart from a ring in which every block is unread. While the ring is full, no new request is issued. An interrupt pulse reports progress every programmable number of finished blocks. Clearing the run bit lets the block already started finish, then returns both pointers to the base.

Top module: `ringdma_ptr_ctrl`

## Requirements
- R1: After reset the run bit, interrupt enable, base, size and threshold are zero. Both pointers are at block 0 with wrap bit 0. No request is pending, `irq` is low, and the status register reads 0b010 (empty).
- R2: While running with the ring not full and a nonzero size, the block starts a request at base + index * BLOCK_BYTES with `req_len` = BLOCK_BYTES. It holds `req_valid` and `req_addr` steady until `req_ready`.
- R3: After the request is accepted, exactly BLOCK_BYTES/(DATA_W/8) beats follow. A beat transfers only when the FIFO is not empty and `dat_ready` is high. Each beat pops one FIFO word and passes it through unchanged, and `dat_last` marks the final beat.
- R4: The write pointer advances by one block in the cycle after the final beat. It reads back at offset 4 as the block address with its wrap bit in bit 0. It changes at no other time except a clear.
- R5: After block index size-1, the write pointer returns to the base and its wrap bit inverts.
- R6: The ring is full when both pointer indices are equal and their wrap bits differ, and empty when the indices and the wrap bits are both equal. No request starts while the ring is full. Status (offset 6) reports bit 0 full, bit 1 empty and bit 2 block in flight.
- R7: A write to offset 3 loads the read pointer from an address in the ring, with its wrap bit in bit 0, and frees space. This write is ignored while the run bit is clear.
- R8: When a finished block brings the blocks counted since the last pulse up to a nonzero threshold (offset 5), `irq` pulses high for exactly one cycle and the count restarts. A threshold of zero never produces a pulse.
- R9: With the interrupt enable (offset 0 bit 1) clear, the count still restarts at the threshold, but `irq` stays low.
- R10: Clearing the run bit (offset 0 bit 0) lets the block in flight finish. Once the block is idle, both pointers and their wrap bits return to zero and the block count is cleared.
- R11: With a size of zero, no request is ever started.
- R12: Register offsets are: 0 control, 1 base, 2 size in blocks, 3 read pointer, 4 write pointer (read only), 5 threshold, 6 status (read only). The base reads back with its low log2(BLOCK_BYTES) bits forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for reads and writes |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data for `cfg_addr` (combinational) |
| src_empty | input | 1 | Source FIFO has no word |
| src_rd_en | output | 1 | Pop one word from the source FIFO |
| src_data | input | DATA_W | Source FIFO head word |
| req_valid | output | 1 | Write request pending |
| req_ready | input | 1 | Write request accepted |
| req_addr | output | ADDR_W | Destination address of the block |
| req_len | output | LEN_W | Block length in bytes |
| dat_valid | output | 1 | Data beat valid |
| dat_ready | input | 1 | Data sink can take a beat |
| dat_data | output | DATA_W | Data beat |
| dat_last | output | 1 | Final beat of the block |
| irq | output | 1 | One-cycle progress interrupt |

## Verification
On every cycle, the assertions check these rules: the request holds steady while stalled, no start is taken into a full ring, the data stream stops after the last beat, the pointers are zero after a clear, full and empty are never both true, and the interrupt is one cycle long, follows a finished block and respects the enable. Other behaviours depend on a history of register writes and flow-control patterns, so only the bench's scenarios show them. These are the wrap of the write pointer with its wrap bit, space freed by a read-pointer update, the exact number of interrupts for a threshold, the masked and zero-threshold cases, the completion of a block in flight after the run bit is cleared, and the rejection of read-pointer writes and of a zero size.

// File: rtl/ringdma_pkg.sv
package ringdma_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] REG_BASE   = 3'd1;
  localparam logic [REG_AW-1:0] REG_SIZE   = 3'd2;
  localparam logic [REG_AW-1:0] REG_RDPTR  = 3'd3;
  localparam logic [REG_AW-1:0] REG_WRPTR  = 3'd4;
  localparam logic [REG_AW-1:0] REG_THRESH = 3'd5;
  localparam logic [REG_AW-1:0] REG_STATUS = 3'd6;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_REQ  = 2'd1,
    XF_DATA = 2'd2
  } xfer_state_t;

endpackage

// File: rtl/ringdma_regs.sv
module ringdma_regs
  import ringdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 16,
  parameter int BSHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_tog,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_tog,
  input  logic              full,
  input  logic              empty,
  input  logic              busy,
  output logic              run_en,
  output logic              irq_en,
  output logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  size,
  output logic [CNT_W-1:0]  thresh,
  output logic              rd_load,
  output logic [IDX_W-1:0]  rd_load_idx,
  output logic              rd_load_tog
);

  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << BSHIFT) - ADDR_W'(1);

  // pointer (index + wrap bit) to its register image
  function automatic logic [ADDR_W-1:0] ptr_image(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0]  idx,
                                                  input logic              tog);
    return (b + (ADDR_W'(idx) << BSHIFT)) | ADDR_W'(tog);
  endfunction

  // address written by software to a block index of the ring
  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] b);
    return IDX_W'((a - b) >> BSHIFT);
  endfunction

  always_comb begin
    rd_load     = cfg_we && (cfg_addr == REG_RDPTR) && run_en;
    rd_load_idx = addr_index(cfg_wdata, base);
    rd_load_tog = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      irq_en <= 1'b0;
      base   <= '0;
      size   <= '0;
      thresh <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_CTRL: begin
          run_en <= cfg_wdata[0];
          irq_en <= cfg_wdata[1];
        end
        REG_BASE:   base   <= cfg_wdata & ~LOW_MASK;
        REG_SIZE:   size   <= cfg_wdata[IDX_W-1:0];
        REG_THRESH: thresh <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      REG_CTRL:   cfg_rdata = {{(ADDR_W-2){1'b0}}, irq_en, run_en};
      REG_BASE:   cfg_rdata = base;
      REG_SIZE:   cfg_rdata = ADDR_W'(size);
      REG_RDPTR:  cfg_rdata = ptr_image(base, rd_idx, rd_tog);
      REG_WRPTR:  cfg_rdata = ptr_image(base, wr_idx, wr_tog);
      REG_THRESH: cfg_rdata = ADDR_W'(thresh);
      REG_STATUS: cfg_rdata = {{(ADDR_W-3){1'b0}}, busy, empty, full};
      default:    cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ringdma_ptrs.sv
module ringdma_ptrs #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [IDX_W-1:0] size,
  input  logic             rd_load,
  input  logic [IDX_W-1:0] rd_load_idx,
  input  logic             rd_load_tog,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_tog,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_tog,
  output logic             full,
  output logic             empty,
  output logic             ptr_wrap
);

  // next block index; MSB of the result says the ring wrapped
  function automatic logic [IDX_W:0] step_index(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] sz);
    logic [IDX_W:0] inc;
    inc = {1'b0, idx} + {{IDX_W{1'b0}}, 1'b1};
    if (inc == {1'b0, sz}) return {1'b1, {IDX_W{1'b0}}};
    return {1'b0, inc[IDX_W-1:0]};
  endfunction

  logic [IDX_W:0] wr_next;

  always_comb begin
    wr_next  = step_index(wr_idx, size);
    ptr_wrap = advance && wr_next[IDX_W];
    full     = (wr_idx == rd_idx) && (wr_tog != rd_tog);
    empty    = (wr_idx == rd_idx) && (wr_tog == rd_tog);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      wr_tog <= 1'b0;
      rd_idx <= '0;
      rd_tog <= 1'b0;
    end else if (clear) begin
      wr_idx <= '0;
      wr_tog <= 1'b0;
      rd_idx <= '0;
      rd_tog <= 1'b0;
    end else begin
      if (advance) begin
        wr_idx <= wr_next[IDX_W-1:0];
        wr_tog <= wr_tog ^ wr_next[IDX_W];
      end
      if (rd_load) begin
        rd_idx <= rd_load_idx;
        rd_tog <= rd_load_tog;
      end
    end
  end

endmodule

// File: rtl/ringdma_xfer.sv
module ringdma_xfer
  import ringdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 16,
  parameter int BEATS  = 128,
  parameter int BSHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              full,
  input  logic [IDX_W-1:0]  size,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              src_empty,
  output logic              src_rd_en,
  input  logic [DATA_W-1:0] src_data,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [DATA_W-1:0] dat_data,
  output logic              dat_last,
  output logic              blk_start,
  output logic              blk_done,
  output logic              busy
);

  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  function automatic logic [ADDR_W-1:0] block_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [IDX_W-1:0]  idx);
    return b + (ADDR_W'(idx) << BSHIFT);
  endfunction

  xfer_state_t       state_q;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic              beat_hs;

  always_comb begin
    busy      = (state_q != XF_IDLE);
    blk_start = (state_q == XF_IDLE) && run_en && !full && (size != '0);
    req_valid = (state_q == XF_REQ);
    req_addr  = addr_q;
    dat_valid = (state_q == XF_DATA) && !src_empty;
    dat_data  = src_data;
    dat_last  = (state_q == XF_DATA) && (beat_q == LAST_BEAT);
    beat_hs   = dat_valid && dat_ready;
    src_rd_en = beat_hs;
    blk_done  = beat_hs && (beat_q == LAST_BEAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      beat_q  <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        XF_IDLE: begin
          if (blk_start) begin
            state_q <= XF_REQ;
            addr_q  <= block_addr(base, wr_idx);
          end
        end
        XF_REQ: begin
          if (req_ready) begin
            state_q <= XF_DATA;
            beat_q  <= '0;
          end
        end
        XF_DATA: begin
          if (beat_hs) begin
            if (beat_q == LAST_BEAT) state_q <= XF_IDLE;
            else                     beat_q  <= beat_q + BEAT_W'(1);
          end
        end
        default: state_q <= XF_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ringdma_irq.sv
module ringdma_irq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [CNT_W-1:0] thresh,
  input  logic             irq_en,
  output logic             irq,
  output logic             irq_fire
);

  logic [CNT_W-1:0] cnt_q;

  // true when one more finished block reaches a nonzero threshold
  function automatic logic hits_threshold(input logic [CNT_W-1:0] cnt,
                                          input logic [CNT_W-1:0] thr);
    logic [CNT_W:0] nxt;
    nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    return (thr != '0) && (nxt >= {1'b0, thr});
  endfunction

  always_comb irq_fire = advance && hits_threshold(cnt_q, thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else if (advance) begin
      if (irq_fire) begin
        cnt_q <= '0;
        irq   <= irq_en;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        irq   <= 1'b0;
      end
    end else begin
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/ringdma_ptr_ctrl.sv
module ringdma_ptr_ctrl
  import ringdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int BLOCK_BYTES = 1024,
  parameter int IDX_W       = 16,
  parameter int CNT_W       = 16,
  localparam int BSHIFT     = $clog2(BLOCK_BYTES),
  localparam int BEATS      = BLOCK_BYTES / (DATA_W / 8),
  localparam int LEN_W      = BSHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              src_empty,
  output logic              src_rd_en,
  input  logic [DATA_W-1:0] src_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [DATA_W-1:0] dat_data,
  output logic              dat_last,
  output logic              irq
);

  logic              run_en, irq_en;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  size;
  logic [CNT_W-1:0]  thresh;
  logic              rd_load, rd_load_tog;
  logic [IDX_W-1:0]  rd_load_idx;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_tog, rd_tog;
  logic              full, empty, busy;

  // named internal events, observed by the checker
  logic blk_start, blk_done, ptr_clear, ptr_wrap, irq_fire;

  assign req_len   = LEN_W'(BLOCK_BYTES);
  assign ptr_clear = !run_en && !busy;

  ringdma_regs #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .BSHIFT(BSHIFT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wr_idx(wr_idx), .wr_tog(wr_tog), .rd_idx(rd_idx), .rd_tog(rd_tog),
    .full(full), .empty(empty), .busy(busy),
    .run_en(run_en), .irq_en(irq_en), .base(base), .size(size), .thresh(thresh),
    .rd_load(rd_load), .rd_load_idx(rd_load_idx), .rd_load_tog(rd_load_tog)
  );

  ringdma_ptrs #(
    .IDX_W(IDX_W)
  ) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .clear(ptr_clear), .advance(blk_done), .size(size),
    .rd_load(rd_load), .rd_load_idx(rd_load_idx), .rd_load_tog(rd_load_tog),
    .wr_idx(wr_idx), .wr_tog(wr_tog), .rd_idx(rd_idx), .rd_tog(rd_tog),
    .full(full), .empty(empty), .ptr_wrap(ptr_wrap)
  );

  ringdma_xfer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .BEATS(BEATS), .BSHIFT(BSHIFT)
  ) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .run_en(run_en), .full(full), .size(size), .base(base), .wr_idx(wr_idx),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .src_empty(src_empty), .src_rd_en(src_rd_en), .src_data(src_data),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data), .dat_last(dat_last),
    .blk_start(blk_start), .blk_done(blk_done), .busy(busy)
  );

  ringdma_irq #(
    .CNT_W(CNT_W)
  ) u_irq (
    .clk(clk), .rst_n(rst_n),
    .clear(ptr_clear), .advance(blk_done), .thresh(thresh), .irq_en(irq_en),
    .irq(irq), .irq_fire(irq_fire)
  );

endmodule

// File: rtl/ringdma_ptr_ctrl_chk.sv
module ringdma_ptr_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              dat_valid,
  input logic              dat_ready,
  input logic              dat_last,
  input logic              irq,
  input logic              irq_en,
  input logic              blk_start,
  input logic              blk_done,
  input logic              ptr_clear,
  input logic              full,
  input logic              empty,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [IDX_W-1:0]  rd_idx,
  input logic              wr_tog,
  input logic              rd_tog
);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R3
  stream_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && dat_ready && dat_last |=> !dat_valid);

  // R4
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(blk_done) && !$past(ptr_clear) |-> $stable(wr_idx) && $stable(wr_tog));

  // R6
  no_start_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> !full);

  // R6
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8
  irq_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(blk_done));

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ptr_clear) |-> (wr_idx == '0) && (rd_idx == '0) && !wr_tog && !rd_tog);

endmodule

bind ringdma_ptr_ctrl ringdma_ptr_ctrl_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_last(dat_last),
  .irq(irq), .irq_en(irq_en),
  .blk_start(blk_start), .blk_done(blk_done), .ptr_clear(ptr_clear),
  .full(full), .empty(empty),
  .wr_idx(wr_idx), .rd_idx(rd_idx), .wr_tog(wr_tog), .rd_tog(rd_tog)
);

// File: tb/ringdma_ptr_ctrl_bench.sv
module ringdma_ptr_ctrl_bench;

  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int BB    = 64;
  localparam int SH    = 6;
  localparam int BEATS = BB / (DW / 8);
  localparam logic [31:0] RB    = 32'h0001_0000;
  localparam logic [31:0] DATA0 = 32'hA500_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = 3'd4;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          src_empty = 1'b1;
  logic          src_rd_en;
  logic [DW-1:0] src_data = DATA0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [SH:0]   req_len;
  logic          dat_valid;
  logic          dat_ready = 1'b0;
  logic [DW-1:0] dat_data;
  logic          dat_last;
  logic          irq;

  ringdma_ptr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BLOCK_BYTES(BB), .IDX_W(16), .CNT_W(16)) u_ringdma_ptr_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_empty(src_empty), .src_rd_en(src_rd_en), .src_data(src_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data), .dat_last(dat_last),
    .irq(irq)
  );

  always #5 clk = ~clk;

  int vectors = 0, fails = 0, irq_seen = 0, req_seen = 0, pat = 0, cyc = 0;
  bit pop_flag = 0, finished = 0;

  // behavioural reference state
  int m_st, m_beat, m_w, m_wt, m_r, m_rt, m_cnt, m_irq, m_pop, m_size, m_thr;
  bit m_run, m_ien;
  logic [31:0] m_base, m_addr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] img(input int idx, input int tog);
    return (m_base + 32'(idx * BB)) | 32'(tog);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_beat = 0; m_w = 0; m_wt = 0; m_r = 0; m_rt = 0; m_cnt = 0; m_irq = 0;
      m_pop = 0; m_size = 0; m_thr = 0; m_run = 0; m_ien = 0; m_base = 0; m_addr = 0;
      pop_flag = 0;
    end else begin
      bit e_dv, e_hs, full, empty, clear, adv;
      logic [31:0] e_rd;
      string tag;
      int n_st, n_beat, n_w, n_wt, n_r, n_rt, n_cnt, n_irq;
      logic [31:0] n_addr;
      full  = (m_w == m_r) && (m_wt != m_rt);
      empty = (m_w == m_r) && (m_wt == m_rt);
      e_dv  = (m_st == 2) && !src_empty;
      e_hs  = e_dv && dat_ready;
      case (cfg_addr)
        3'd0: begin e_rd = {30'd0, m_ien, m_run}; tag = "R12"; end
        3'd1: begin e_rd = m_base; tag = "R12"; end
        3'd2: begin e_rd = 32'(m_size); tag = "R12"; end
        3'd3: begin e_rd = img(m_r, m_rt); tag = "R7"; end
        3'd4: begin e_rd = img(m_w, m_wt); tag = "R4"; end
        3'd5: begin e_rd = 32'(m_thr); tag = "R12"; end
        3'd6: begin e_rd = {29'd0, m_st != 0, empty, full}; tag = "R6"; end
        default: begin e_rd = 0; tag = "R12"; end
      endcase
      chk(req_valid == (m_st == 1), "R2", "req_valid", 64'(req_valid), 64'(m_st == 1));
      if (m_st == 1) chk(req_addr == m_addr, "R2", "req_addr", 64'(req_addr), 64'(m_addr));
      chk(req_len == 7'(BB), "R2", "req_len", 64'(req_len), 64'(BB));
      chk(dat_valid == e_dv, "R3", "dat_valid", 64'(dat_valid), 64'(e_dv));
      chk(src_rd_en == e_hs, "R3", "src_rd_en", 64'(src_rd_en), 64'(e_hs));
      if (e_dv) begin
        chk(dat_data == DATA0 + 32'(m_pop), "R3", "dat_data", 64'(dat_data), 64'(DATA0 + 32'(m_pop)));
        chk(dat_last == (m_beat == BEATS - 1), "R3", "dat_last", 64'(dat_last), 64'(m_beat == BEATS - 1));
      end
      chk(irq == m_irq[0], "R8", "irq", 64'(irq), 64'(m_irq));
      chk(cfg_rdata == e_rd, tag, "cfg_rdata", 64'(cfg_rdata), 64'(e_rd));
      if (irq) irq_seen++;
      if (req_valid) req_seen++;
      pop_flag = src_rd_en;
      // advance the reference by one clock
      clear = !m_run && (m_st == 0);
      adv   = e_hs && (m_beat == BEATS - 1);
      n_st = m_st; n_beat = m_beat; n_w = m_w; n_wt = m_wt; n_r = m_r; n_rt = m_rt;
      n_cnt = m_cnt; n_irq = 0; n_addr = m_addr;
      if (m_st == 0) begin
        if (m_run && !full && m_size != 0) begin n_st = 1; n_addr = img(m_w, 0); end
      end else if (m_st == 1) begin
        if (req_ready) begin n_st = 2; n_beat = 0; end
      end else if (e_hs) begin
        if (m_beat == BEATS - 1) n_st = 0; else n_beat = m_beat + 1;
      end
      if (clear) begin
        n_w = 0; n_wt = 0; n_r = 0; n_rt = 0; n_cnt = 0;
      end else begin
        if (adv) begin
          if (m_w + 1 == m_size) begin n_w = 0; n_wt = 1 - m_wt; end
          else n_w = m_w + 1;
          if (m_thr != 0 && m_cnt + 1 >= m_thr) begin n_cnt = 0; n_irq = m_ien; end
          else n_cnt = (m_cnt + 1) % 65536;
        end
        if (cfg_we && cfg_addr == 3'd3 && m_run) begin
          n_r  = int'(((cfg_wdata - m_base) >> SH) & 32'hFFFF);
          n_rt = int'(cfg_wdata[0]);
        end
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin m_run = cfg_wdata[0]; m_ien = cfg_wdata[1]; end
          3'd1: m_base = cfg_wdata & ~32'h3F;
          3'd2: m_size = int'(cfg_wdata[15:0]);
          3'd5: m_thr = int'(cfg_wdata[15:0]);
          default: ;
        endcase
      end
      if (e_hs) m_pop++;
      m_st = n_st; m_beat = n_beat; m_w = n_w; m_wt = n_wt; m_r = n_r; m_rt = n_rt;
      m_cnt = n_cnt; m_irq = n_irq; m_addr = n_addr;
    end
  end

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #3;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #3;
    cfg_we = 1'b0; cfg_addr = 3'd4;
  endtask

  task automatic reg_expect(input logic [2:0] a, input logic [31:0] exp,
                            input string tag, input string what);
    @(posedge clk); #3;
    cfg_addr = a;
    @(negedge clk); #1;
    chk(cfg_rdata == exp, tag, what, 64'(cfg_rdata), 64'(exp));
    cfg_addr = 3'd4;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements): run not complete, actual hung expected done");
      summary();
    end
  end

  initial begin : stim
    int irq_base;
    fork
      forever begin
        @(posedge clk); #2;
        cyc++;
        if (pop_flag) src_data = src_data + 1;
        pop_flag = 0;
        if (pat == 0) begin
          req_ready = 1'b1; dat_ready = 1'b1; src_empty = 1'b0;
        end else begin
          req_ready = (cyc % 3) == 0;
          dat_ready = (cyc % 5) != 1;
          src_empty = (cyc % 7) == 3;
        end
      end
    join_none

    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state
    reg_expect(3'd6, 32'h2, "R1", "status after reset");
    reg_expect(3'd4, 32'h0, "R1", "wrptr after reset");
    reg_expect(3'd0, 32'h0, "R1", "ctrl after reset");

    // R12: base low bits dropped
    cfg_wr(3'd1, RB | 32'h3F);
    reg_expect(3'd1, RB, "R12", "base alignment");
    cfg_wr(3'd2, 32'd4);
    cfg_wr(3'd5, 32'd2);

    // R2 R3 R5 R6 R8: fill the ring under throttled flow control
    pat = 1;
    irq_seen = 0;
    cfg_wr(3'd0, 32'h3);
    repeat (600) @(posedge clk);
    reg_expect(3'd4, RB | 32'h1, "R5", "wrptr wrapped to base");
    reg_expect(3'd6, 32'h1, "R6", "status full");
    req_seen = 0;
    repeat (40) @(posedge clk);
    chk(req_seen == 0, "R6", "requests while full", 64'(req_seen), 64'd0);
    chk(irq_seen == 2, "R8", "irq pulses after 4 blocks", 64'(irq_seen), 64'd2);

    // R7: read pointer frees two blocks
    cfg_wr(3'd3, RB + 32'h80);
    repeat (400) @(posedge clk);
    reg_expect(3'd4, (RB + 32'h80) | 32'h1, "R7", "wrptr after freeing two");
    reg_expect(3'd6, 32'h1, "R6", "status full again");
    chk(irq_seen == 3, "R8", "irq pulses after 6 blocks", 64'(irq_seen), 64'd3);

    // R9: masked interrupt, full speed
    pat = 0;
    cfg_wr(3'd0, 32'h1);
    cfg_wr(3'd3, (RB + 32'h80) | 32'h1);
    repeat (300) @(posedge clk);
    reg_expect(3'd4, RB + 32'h80, "R9", "wrptr after masked run");
    chk(irq_seen == 3, "R9", "irq pulses while masked", 64'(irq_seen), 64'd3);

    // R8: zero threshold never pulses
    cfg_wr(3'd5, 32'd0);
    cfg_wr(3'd0, 32'h3);
    cfg_wr(3'd3, RB + 32'h80);
    repeat (300) @(posedge clk);
    reg_expect(3'd4, (RB + 32'h80) | 32'h1, "R8", "wrptr after zero-threshold run");
    chk(irq_seen == 3, "R8", "irq pulses with zero threshold", 64'(irq_seen), 64'd3);

    // R10: stop while a block is in flight
    pat = 1;
    cfg_wr(3'd3, (RB + 32'h80) | 32'h1);
    do @(negedge clk); while (!dat_valid);
    cfg_wr(3'd0, 32'h0);
    repeat (200) @(posedge clk);
    reg_expect(3'd4, RB, "R10", "wrptr cleared after stop");
    reg_expect(3'd3, RB, "R10", "rdptr cleared after stop");
    reg_expect(3'd6, 32'h2, "R10", "status idle empty after stop");

    // R7: read pointer write ignored while stopped
    cfg_wr(3'd3, (RB + 32'h40) | 32'h1);
    reg_expect(3'd3, RB, "R7", "rdptr write while stopped");

    // R11: zero size never starts
    cfg_wr(3'd2, 32'd0);
    cfg_wr(3'd0, 32'h1);
    req_seen = 0;
    repeat (60) @(posedge clk);
    chk(req_seen == 0, "R11", "requests with zero size", 64'(req_seen), 64'd0);
    reg_expect(3'd6, 32'h2, "R11", "status with zero size");
    cfg_wr(3'd0, 32'h0);

    repeat (5) @(posedge clk);
    finished = 1;
    summary();
  end

endmodule